// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer with Watchdog

This block is a register-mapped timer peripheral. It holds four independent down-counters and one watchdog counter. A simple word-addressed register bus reaches all of them: a write strobe, a word address, write data, and read data that follows the address in the same cycle. Each timer has a reload register and a live count register, and software may write either one at any time. One shared control word holds three settings per timer: it enables the timer, it chooses between one-shot and auto-reload, and it picks the tick source. The tick source is either every core clock cycle or a slower reference strobe. That strobe is one cycle wide and already synchronous to the core clock.

In one-shot mode a timer that runs down stops at zero and raises a sticky expiry flag. The flag stays high until software rewrites the count. In auto-reload mode the timer loads its reload value on the tick that finds it at zero. With an all-ones reload it behaves as a free-running wrapping counter, which suits a system time base. The watchdog counts core clocks while it is enabled. When it reaches zero it pulses a reset output for one cycle and restarts from its own reload register.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads zero, every expiry flag is low and the watchdog reset output is low.
- R2: The control word (word address 0) holds these fields. Bit 2n enables timer n and bit 2n+1 selects auto-reload for timer n. Bit 8 enables the watchdog. Bit 11+n selects the reference tick for timer n. All other bits read zero and ignore writes, so the readable mask is 0x79FF.
- R3: An enabled timer whose source bit is clear decrements by exactly one on every core clock edge.
- R4: An enabled timer whose source bit is set decrements by one only on clock edges where the reference strobe is high.
- R5: A timer whose enable bit is clear holds its count.
- R6: In auto-reload mode, a tick that finds the count at zero loads the reload value, and no expiry flag is raised. With reload 0xFFFFFFFF the sequence runs 1, 0, 0xFFFFFFFF, 0xFFFFFFFE.
- R7: In one-shot mode, a tick that leaves the count at zero, or finds it there, keeps the count at zero and sets that timer's sticky expiry flag.
- R8: A write to a count register (word 5+2n) loads the written value, even on a cycle where a tick would have decremented it, and it clears that timer's expiry flag.
- R9: A reload register (word 4+2n) reads back its last written value, and writing it does not change the live count.
- R10: While bit 8 is set, the watchdog count (word 13) decrements every cycle. A cycle that finds it at zero drives the reset output high for the next cycle and loads the watchdog reload value (word 12). With bit 8 clear the output stays low.
- R11: Word addresses 1, 2, 3, 14 and 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference tick strobe, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| tmr_expired | output | 4 | Sticky one-shot expiry flag per timer |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench drives a count-register write on a cycle where the timer is enabled. A design that let the decrement win would read back one less than the value written, and it would leave the expiry flag set. The bench walks an auto-reload timer with an all-ones reload through the zero crossing. A design that reloaded one tick late, or raised the one-shot flag in auto mode, would show a different count at that point. The bench gates a timer on a sparse reference strobe. If the decrement leaked through on plain clock cycles, the timer would end far below the expected count. The bench also counts watchdog pulses over a fixed window. It writes to reserved words and to unused control bits and then reads them back. A mis-decoded address would alias into a live register and show up in those reads.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned DEF_NUM_TMR = 4;
  localparam int unsigned DEF_CNT_W   = 32;
  localparam int unsigned WD_EN_BIT   = 8;
  localparam int unsigned REF_BASE    = 11;
  localparam int unsigned TMR_BASE_WA = 4;

  function automatic int unsigned en_bit(input int unsigned n);
    return 2 * n;
  endfunction

  function automatic int unsigned auto_bit(input int unsigned n);
    return 2 * n + 1;
  endfunction

  function automatic int unsigned ref_bit(input int unsigned n);
    return REF_BASE + n;
  endfunction
endpackage

// File: rtl/tmr_ctrl_reg.sv
`timescale 1ns/1ps
module tmr_ctrl_reg
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = DEF_NUM_TMR,
  parameter int unsigned DATA_W  = DEF_CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_TMR-1:0] en_o,
  output logic [NUM_TMR-1:0] auto_o,
  output logic [NUM_TMR-1:0] ref_o,
  output logic               wd_en_o,
  output logic [DATA_W-1:0]  rd_o
);
  logic [NUM_TMR-1:0] en_q, en_d, auto_q, auto_d, ref_q, ref_d;
  logic               wd_q, wd_d;
  logic               unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    en_d   = en_q;
    auto_d = auto_q;
    ref_d  = ref_q;
    wd_d   = wd_q;
    if (we) begin
      for (int n = 0; n < NUM_TMR; n++) begin
        en_d[n]   = wdata[en_bit(n)];
        auto_d[n] = wdata[auto_bit(n)];
        ref_d[n]  = wdata[ref_bit(n)];
      end
      wd_d = wdata[WD_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      auto_q <= '0;
      ref_q  <= '0;
      wd_q   <= 1'b0;
    end else if (we) begin
      en_q   <= en_d;
      auto_q <= auto_d;
      ref_q  <= ref_d;
      wd_q   <= wd_d;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int n = 0; n < NUM_TMR; n++) begin
      rd_o[en_bit(n)]   = en_q[n];
      rd_o[auto_bit(n)] = auto_q[n];
      rd_o[ref_bit(n)]  = ref_q[n];
    end
    rd_o[WD_EN_BIT] = wd_q;
  end

  assign en_o    = en_q;
  assign auto_o  = auto_q;
  assign ref_o   = ref_q;
  assign wd_en_o = wd_q;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rd_o))
    else $error("control word changed without a write");
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             auto_mode,
  input  logic             val_we,
  input  logic             rel_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rel_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d;
  logic             flag_q, flag_d;
  logic             at_zero, at_one;

  assign at_zero = (cnt_q == '0);
  assign at_one  = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (val_we) begin
      cnt_d  = wdata;
      flag_d = 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        if (auto_mode) cnt_d = rel_q;
        else           flag_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
        if (at_one && !auto_mode) flag_d = 1'b1;
      end
    end
    rel_d = rel_we ? wdata : rel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (val_we || tick) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rel_q <= '0;
    else if (rel_we) rel_q <= rel_d;
  end

  assign cnt_o     = cnt_q;
  assign rel_o     = rel_q;
  assign expired_o = flag_q;

  a_r3_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !val_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)))
    else $error("count did not step down by one");
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !val_we) |=> $stable(cnt_q))
    else $error("count moved without a tick");
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !val_we && auto_mode && cnt_q == '0) |=> (cnt_q == $past(rel_q) && !$rose(flag_q)))
    else $error("auto reload failed");
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !val_we) |=> flag_q)
    else $error("expiry flag dropped without a count write");
  a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
    val_we |=> (cnt_q == $past(wdata) && !flag_q))
    else $error("count write lost or flag not cleared");
  a_r9_rel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_we |=> $stable(rel_q))
    else $error("reload changed without a write");
endmodule

// File: rtl/tmr_wdog.sv
`timescale 1ns/1ps
module tmr_wdog
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             val_we,
  input  logic             rel_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rel_o,
  output logic             rst_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q;
  logic             fire_q, fire_d;

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (val_we) begin
      cnt_d = wdata;
    end else if (en) begin
      if (cnt_q == '0) begin
        fire_d = 1'b1;
        cnt_d  = rel_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= fire_d;
      if (val_we || en) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rel_q <= '0;
    else if (rel_we) rel_q <= wdata;
  end

  assign cnt_o = cnt_q;
  assign rel_o = rel_q;
  assign rst_o = fire_q;

  a_r10_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !val_we && cnt_q == '0) |=> (rst_o && cnt_q == $past(rel_q)))
    else $error("watchdog expiry missed");
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rst_o)
    else $error("watchdog fired while disabled");
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = DEF_NUM_TMR,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned AW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  output logic [NUM_TMR-1:0] tmr_expired,
  output logic               wdog_rst
);
  localparam int unsigned WD_REL_WA = TMR_BASE_WA + 2 * NUM_TMR;
  localparam int unsigned WD_VAL_WA = WD_REL_WA + 1;

  logic [NUM_TMR-1:0] t_en, t_auto, t_ref, t_tick, t_val_we, t_rel_we;
  logic               wd_en;
  logic [CNT_W-1:0]   ctrl_rd, wd_cnt, wd_rel;
  logic [CNT_W-1:0]   t_cnt [NUM_TMR];
  logic [CNT_W-1:0]   t_rel [NUM_TMR];

  tmr_ctrl_reg #(.NUM_TMR(NUM_TMR), .DATA_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we && bus_addr == '0),
    .wdata   (bus_wdata),
    .en_o    (t_en),
    .auto_o  (t_auto),
    .ref_o   (t_ref),
    .wd_en_o (wd_en),
    .rd_o    (ctrl_rd)
  );

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
    assign t_tick[n]   = t_en[n] && (t_ref[n] ? ref_tick : 1'b1);
    assign t_rel_we[n] = bus_we && (bus_addr == AW'(TMR_BASE_WA + 2 * n));
    assign t_val_we[n] = bus_we && (bus_addr == AW'(TMR_BASE_WA + 2 * n + 1));

    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (t_tick[n]),
      .auto_mode (t_auto[n]),
      .val_we    (t_val_we[n]),
      .rel_we    (t_rel_we[n]),
      .wdata     (bus_wdata),
      .cnt_o     (t_cnt[n]),
      .rel_o     (t_rel[n]),
      .expired_o (tmr_expired[n])
    );

    a_r4_ref_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (t_ref[n] && !ref_tick && !t_val_we[n]) |=> $stable(t_cnt[n]))
      else $error("timer counted without a reference strobe");
  end

  tmr_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (wd_en),
    .val_we (bus_we && bus_addr == AW'(WD_VAL_WA)),
    .rel_we (bus_we && bus_addr == AW'(WD_REL_WA)),
    .wdata  (bus_wdata),
    .cnt_o  (wd_cnt),
    .rel_o  (wd_rel),
    .rst_o  (wdog_rst)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = ctrl_rd;
    for (int n = 0; n < NUM_TMR; n++) begin
      if (bus_addr == AW'(TMR_BASE_WA + 2 * n))     bus_rdata = t_rel[n];
      if (bus_addr == AW'(TMR_BASE_WA + 2 * n + 1)) bus_rdata = t_cnt[n];
    end
    if (bus_addr == AW'(WD_REL_WA)) bus_rdata = wd_rel;
    if (bus_addr == AW'(WD_VAL_WA)) bus_rdata = wd_cnt;
  end

  a_r11_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != '0 && bus_addr < AW'(TMR_BASE_WA)) |-> (bus_rdata == '0))
    else $error("reserved word read nonzero");
endmodule

// File: tb/tb_tmr_bank.sv
`timescale 1ns/1ps
module tb_tmr_bank;
  localparam int NT = 4;
  localparam int W  = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          ref_tick = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [NT-1:0] tmr_expired;
  logic          wdog_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl, m_wrel, m_wval;
  logic [31:0] m_val [NT];
  logic [31:0] m_rel [NT];
  logic [NT-1:0] m_flag;
  logic m_wrst;

  tmr_bank dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_expired(tmr_expired), .wdog_rst(wdog_rst)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [AW-1:0] a);
    int ia;
    ia = int'(a);
    if (ia == 0) return m_ctrl;
    if (ia >= 4 && ia <= 11) return a[0] ? m_val[(ia - 4) / 2] : m_rel[(ia - 4) / 2];
    if (ia == 12) return m_wrel;
    if (ia == 13) return m_wval;
    return 32'h0;
  endfunction

  // Behavioural reference, advanced on every clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_wrel = 0; m_wval = 0; m_flag = '0; m_wrst = 0;
      for (int n = 0; n < NT; n++) begin m_val[n] = 0; m_rel[n] = 0; end
    end else begin
      logic [31:0] oc;
      logic tk;
      oc = m_ctrl;
      for (int n = 0; n < NT; n++) begin
        tk = oc[2*n] && (oc[11+n] ? ref_tick : 1'b1);
        if (bus_we && int'(bus_addr) == 5 + 2*n) begin
          m_val[n] = bus_wdata; m_flag[n] = 1'b0;
        end else if (tk) begin
          if (m_val[n] == 0) begin
            if (oc[2*n+1]) m_val[n] = m_rel[n];
            else m_flag[n] = 1'b1;
          end else begin
            m_val[n] = m_val[n] - 1;
            if (m_val[n] == 0 && !oc[2*n+1]) m_flag[n] = 1'b1;
          end
        end
        if (bus_we && int'(bus_addr) == 4 + 2*n) m_rel[n] = bus_wdata;
      end
      m_wrst = 1'b0;
      if (bus_we && bus_addr == 13) m_wval = bus_wdata;
      else if (oc[8]) begin
        if (m_wval == 0) begin m_wrst = 1'b1; m_wval = m_wrel; end
        else m_wval = m_wval - 1;
      end
      if (bus_we && bus_addr == 12) m_wrel = bus_wdata;
      if (bus_we && bus_addr == 0) m_ctrl = bus_wdata & 32'h0000_79FF;
    end
  end

  // Per-cycle comparison against the reference (R3 R6 R7 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      chk("R3 R6 model rdata", bus_rdata, mread(bus_addr));
      chk("R7 model expired", {28'h0, tmr_expired}, {28'h0, m_flag});
      chk("R10 model wdog_rst", {31'h0, wdog_rst}, {31'h0, m_wrst});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    bus_addr = AW'(a);
    #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pulses;
    bit prev, consec;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    foreach (bus_addr[i]) ;
    rd(0, 0, "R1 reset ctrl");
    rd(5, 0, "R1 reset count");
    rd(4, 0, "R1 reset reload");
    rd(13, 0, "R1 reset wdog count");
    chk("R1 reset expired", {28'h0, tmr_expired}, 32'h0);
    chk("R1 reset wdog_rst", {31'h0, wdog_rst}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reserved words
    wr(1, 32'hDEAD_BEEF); wr(2, 32'h1234_5678); wr(3, 32'hFFFF_FFFF);
    wr(14, 32'hA5A5_A5A5); wr(15, 32'h5A5A_5A5A);
    rd(1, 0, "R11 rsvd 1"); rd(3, 0, "R11 rsvd 3"); rd(15, 0, "R11 rsvd 15");
    rd(0, 0, "R11 ctrl untouched"); rd(5, 0, "R11 count untouched");

    // R2: unused control bits
    wr(0, 32'hFFFF_8600);
    rd(0, 0, "R2 unused bits read zero");

    // R3 then R5
    wr(5, 100);
    wr(0, 32'h1);
    wr(0, 32'h0);
    rd(5, 99, "R3 one decrement per clock");
    repeat (5) @(negedge clk);
    rd(5, 99, "R5 disabled holds");

    // R4: reference strobe gating
    wr(0, 32'h801);
    rd(0, 32'h801, "R2 control readback");
    for (int i = 0; i < 5; i++) begin
      ref_tick = 1'b1; @(negedge clk);
      ref_tick = 1'b0; repeat (3) @(negedge clk);
    end
    wr(0, 32'h0);
    rd(5, 94, "R4 counts only on strobes");

    // R7 one-shot, R8 write priority
    wr(5, 3);
    wr(0, 32'h1);
    repeat (6) @(negedge clk);
    bus_addr = 4'd5; #1;
    chk("R7 stops at zero", bus_rdata, 0);
    chk("R7 sticky flag", {31'h0, tmr_expired[0]}, 32'h1);
    @(negedge clk);
    wr(5, 5);
    bus_addr = 4'd5; #1;
    chk("R8 write beats decrement", bus_rdata, 5);
    chk("R8 write clears flag", {31'h0, tmr_expired[0]}, 32'h0);
    @(negedge clk);
    wr(0, 32'h0);

    // R6 auto-reload wrap
    wr(6, 32'hFFFF_FFFF);
    wr(7, 1);
    wr(0, 32'hC);
    bus_addr = 4'd7; #1;
    chk("R6 start", bus_rdata, 1);
    @(negedge clk); #1; chk("R6 reaches zero", bus_rdata, 0);
    @(negedge clk); #1; chk("R6 wraps to all ones", bus_rdata, 32'hFFFF_FFFF);
    @(negedge clk); #1; chk("R6 continues", bus_rdata, 32'hFFFF_FFFE);
    chk("R6 no flag in auto mode", {31'h0, tmr_expired[1]}, 32'h0);
    @(negedge clk);
    wr(0, 32'h0);

    // R9 reload independent of count
    rd(6, 32'hFFFF_FFFF, "R9 reload readback");
    wr(6, 5);
    rd(7, 32'hFFFF_FFFC, "R9 reload write leaves count");
    rd(6, 5, "R9 new reload");

    // R10 watchdog
    wr(12, 3);
    wr(13, 2);
    wr(0, 32'h100);
    pulses = 0; prev = 1'b0; consec = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #1;
      if (wdog_rst) pulses++;
      if (wdog_rst && prev) consec = 1'b1;
      prev = wdog_rst;
    end
    @(negedge clk);
    chk("R10 pulse count", pulses, 3);
    chk("R10 single-cycle pulses", {31'h0, consec}, 32'h0);
    wr(0, 32'h0);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (wdog_rst) pulses++;
    end
    @(negedge clk);
    chk("R10 disabled no pulse", pulses, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule